// File: doc/BRIEF.md
# Multi-Digit Decimal Ripple Adder

This block adds two unsigned decimal numbers held in packed BCD form, together with a single-bit carry-in. It returns a packed-BCD sum and a decimal carry-out. The width in decimal digits is a parameter, three by default. Each digit position has its own slice. A slice first forms an ordinary 5-bit binary sum of its two digits and the carry it receives. A gate-level test on that raw sum then decides whether a decimal carry is produced. When it is, the slice corrects the low nibble by adding six.

The slices pass the decimal carry from the least significant digit toward the most significant one. The carry out of the top digit becomes the block's carry-out. The sum and carry can go through one output register or straight out to the ports, and a parameter picks which. Operand digits are assumed to be valid BCD (0 to 9). Nothing inside the block checks that.

Top module: `bcd_cascade_adder`

## Requirements
- R1: Each digit slice forms a 5-bit binary sum {K,Z8,Z4,Z2,Z1} equal to its A digit plus its B digit plus its incoming carry. For valid digits this sum never exceeds 19.
- R2: When a slice's binary sum is 9 or less, its output digit equals the low 4 bits of that sum and its decimal carry is 0.
- R3: A slice's decimal carry is K | (Z8 & Z4) | (Z8 & Z2). It is therefore 1 for binary sums from 10 to 15 through the Z8 terms, and for sums from 16 to 19 through K.
- R4: When a slice's decimal carry is 1, its output digit is the low 4 bits of the binary sum plus 0110, taken modulo 16. For example, 7 + 6 with no carry gives digit 0011 and carry 1.
- R5: The incoming carry of digit 0 is cin_i. The incoming carry of digit i+1 is the decimal carry of digit i. The decimal carry of the top digit drives cout_o.
- R6: Digit i of a_i, b_i and sum_o sits in bits [4i+3:4i]. The value of {cout_o, sum_o} read as decimal equals A + B + cin_i. For example, 538 + 247 with carry-in 0 gives 785 with carry-out 0.
- R7: With REG_OUT = 1 (the default), sum_o and cout_o change only at a rising clock edge, and they show the result for the inputs present just before that edge. With REG_OUT = 0 the outputs follow the inputs with no clock.
- R8: While rst_n is low (REG_OUT = 1), sum_o and cout_o are held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | 4*DIGITS | First operand, packed BCD |
| b_i | input | 4*DIGITS | Second operand, packed BCD |
| cin_i | input | 1 | Decimal carry into digit 0 |
| sum_o | output | 4*DIGITS | Packed-BCD sum |
| cout_o | output | 1 | Decimal carry out of the top digit |

## Verification
Every pair of single digits is applied in digit 0 with both carry-in values. This tells apart the three slice outcomes: a plain pass-through (sum up to 9), a carry raised by the Z8 terms (10 to 15), and a carry raised by K (16 to 19). Directed multi-digit operands such as 999 + 000 + 1 and 999 + 999 + 1 force the carry to ripple through every slice and out of the top. The quoted example sums pin down the digit packing. Random valid operands from a fixed seed are compared against a decimal model. A check a quarter period after an input change, taken before the edge, separates the registered output from a combinational one.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;

  typedef logic [3:0] digit_t;
  typedef logic [4:0] raw_t;

  localparam digit_t DEC_FIX = 4'b0110;

  // 5-bit binary sum of two digits and a carry
  function automatic raw_t digit_bin_sum(digit_t a, digit_t b, logic c);
    return raw_t'({1'b0, a}) + raw_t'({1'b0, b}) + raw_t'(c);
  endfunction

  // decimal carry from raw bits {K,Z8,Z4,Z2,Z1}
  function automatic logic dec_carry(raw_t z);
    return z[4] | (z[3] & z[2]) | (z[3] & z[1]);
  endfunction

  // corrected digit; overflow past 4 bits is dropped
  function automatic digit_t dec_fix(raw_t z, logic c);
    return c ? (z[3:0] + DEC_FIX) : z[3:0];
  endfunction

endpackage

// File: rtl/bcd_digit_slice.sv
module bcd_digit_slice
  import bcd_add_pkg::*;
(
  input  logic [3:0] dig_a,
  input  logic [3:0] dig_b,
  input  logic       c_in,
  output logic [3:0] dig_s,
  output logic       c_out,
  output logic [4:0] raw_o
);

  raw_t z;
  logic carry_w;

  always_comb begin
    z       = digit_bin_sum(dig_a, dig_b, c_in);
    carry_w = dec_carry(z);
  end

  assign raw_o = z;
  assign c_out = carry_w;
  assign dig_s = dec_fix(z, carry_w);

endmodule

// File: rtl/bcd_out_stage.sv
module bcd_out_stage #(
  parameter int W       = 13,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_comb
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/bcd_cascade_adder.sv
module bcd_cascade_adder #(
  parameter int DIGITS  = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4*DIGITS-1:0]   a_i,
  input  logic [4*DIGITS-1:0]   b_i,
  input  logic                  cin_i,
  output logic [4*DIGITS-1:0]   sum_o,
  output logic                  cout_o
);

  localparam int W  = 4 * DIGITS;
  localparam int RW = 5 * DIGITS;

  // named internal events for the checker
  logic [DIGITS:0] chain_c;
  logic [RW-1:0]   raw_bus;
  logic [W-1:0]    sum_comb;

  assign chain_c[0] = cin_i;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_slice
      bcd_digit_slice u_slice (
        .dig_a (a_i[4*i +: 4]),
        .dig_b (b_i[4*i +: 4]),
        .c_in  (chain_c[i]),
        .dig_s (sum_comb[4*i +: 4]),
        .c_out (chain_c[i+1]),
        .raw_o (raw_bus[5*i +: 5])
      );
    end
  endgenerate

  bcd_out_stage #(.W(W + 1), .REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({chain_c[DIGITS], sum_comb}),
    .q     ({cout_o, sum_o})
  );

endmodule

// File: rtl/bcd_cascade_adder_chk.sv
module bcd_cascade_adder_chk #(
  parameter int DIGITS  = 3,
  parameter bit REG_OUT = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [4*DIGITS-1:0]   a_i,
  input logic [4*DIGITS-1:0]   b_i,
  input logic                  cin_i,
  input logic [4*DIGITS-1:0]   sum_o,
  input logic                  cout_o,
  input logic [DIGITS:0]       chain_c,
  input logic [5*DIGITS-1:0]   raw_bus,
  input logic [4*DIGITS-1:0]   sum_comb
);

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      logic [3:0] da, db, ds;
      logic [4:0] z;
      assign da = a_i[4*i +: 4];
      assign db = b_i[4*i +: 4];
      assign ds = sum_comb[4*i +: 4];
      assign z  = raw_bus[5*i +: 5];

      // R1: raw sum tracks operands and never exceeds 19 for valid digits
      p_raw_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (da <= 4'd9 && db <= 4'd9) |-> (z == 5'(da) + 5'(db) + 5'(chain_c[i]) && z <= 5'd19));

      // R2: small sums pass through with no carry
      p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (z <= 5'd9) |-> (ds == z[3:0] && !chain_c[i+1]));

      // R3: carry out is raised exactly for sums of ten or more
      p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chain_c[i+1] == (z >= 5'd10));

      // R4: corrected digit for sums of ten or more
      p_fix_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (z >= 5'd10) |-> (ds == 4'(z[3:0] + 4'd6)));
    end
  endgenerate

  // R5: ripple entry and exit
  p_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chain_c[0] == cin_i);

  generate
    if (REG_OUT) begin : g_regchk
      // R7: outputs show the previous cycle's combinational result
      p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({cout_o, sum_o} == $past({chain_c[DIGITS], sum_comb})));
      // R8: reset holds outputs at zero
      p_reset_r8: assert property (@(posedge clk)
        !rst_n |-> (sum_o == '0 && !cout_o));
    end else begin : g_combchk
      // R5 / R7: top carry reaches the port directly
      p_cout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cout_o == chain_c[DIGITS]);
    end
  endgenerate

endmodule

bind bcd_cascade_adder bcd_cascade_adder_chk #(.DIGITS(DIGITS), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .a_i      (a_i),
  .b_i      (b_i),
  .cin_i    (cin_i),
  .sum_o    (sum_o),
  .cout_o   (cout_o),
  .chain_c  (chain_c),
  .raw_bus  (raw_bus),
  .sum_comb (sum_comb)
);

// File: tb/bcd_cascade_adder_bench.sv
module bcd_cascade_adder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIGITS     = 3;
  localparam int W          = 4 * DIGITS;
  localparam int LIMIT      = 10 ** DIGITS;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         cin_i = 1'b0;
  logic [W-1:0] sum_o;
  logic         cout_o;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bcd_cascade_adder #(.DIGITS(DIGITS), .REG_OUT(1'b1)) u_bcd_cascade_adder (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
  );

  function automatic logic [W-1:0] to_bcd(int v);
    logic [W-1:0] r = '0;
    int t = v;
    for (int k = 0; k < DIGITS; k++) begin
      r[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  // decimal model: returns {cout, sum}
  function automatic logic [W:0] ref_add(int a, int b, bit c);
    int s = a + b + int'(c);
    return {(s >= LIMIT), to_bcd(s % LIMIT)};
  endfunction

  task automatic check(string tag, logic [W:0] got, logic [W:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic run_add(string tag, int a, int b, bit c);
    @(negedge clk);
    a_i = to_bcd(a); b_i = to_bcd(b); cin_i = c;
    @(negedge clk);
    check(tag, {cout_o, sum_o}, ref_add(a, b, c));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [W:0] prev;
    void'($urandom(32'd4242));
    // R8: outputs cleared during reset
    a_i = to_bcd(123); b_i = to_bcd(456);
    repeat (3) @(negedge clk);
    check("R8 reset", {cout_o, sum_o}, '0);
    rst_n = 1'b1;

    // R1 R2 R3 R4: exhaustive single-digit pairs, both carry-in values
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 2; c++) begin
          int s = a + b + c;
          if (s <= 9)       run_add("R1 R2 pass", a, b, c[0]);
          else if (s <= 15) run_add("R3 R4 z8 carry", a, b, c[0]);
          else              run_add("R3 R4 k carry", a, b, c[0]);
        end

    run_add("R4 seven plus six", 7, 6, 1'b0);
    run_add("R6 example", 538, 247, 1'b0);
    run_add("R5 full ripple", 999, 0, 1'b1);
    run_add("R5 max", 999, 999, 1'b1);
    run_add("R5 mid ripple", 95, 5, 1'b0);
    run_add("R6 zero", 0, 0, 1'b0);

    // R7: output holds until the next rising edge
    run_add("R7 setup", 111, 222, 1'b0);
    prev = {cout_o, sum_o};
    @(negedge clk);
    a_i = to_bcd(888); b_i = to_bcd(777); cin_i = 1'b1;
    #(CLK_PERIOD / 4);
    check("R7 hold before edge", {cout_o, sum_o}, prev);
    @(negedge clk);
    check("R7 after edge", {cout_o, sum_o}, ref_add(888, 777, 1'b1));

    // R6: random valid operands
    for (int n = 0; n < 400; n++)
      run_add("R6 random", int'($urandom_range(LIMIT - 1)),
              int'($urandom_range(LIMIT - 1)), 1'($urandom_range(1)));

    // R8: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #(CLK_PERIOD / 4);
    check("R8 async clear", {cout_o, sum_o}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    run_add("R8 recover", 450, 550, 1'b0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule